// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer with Flash Abort

This block decides when a programmable memory peripheral may be accessed after reset. It watches an active-low reset pin and measures each low pulse in clock cycles. Until the first power-on reset has been accepted, a pulse must reach a long cold minimum. After that, a much shorter warm minimum is enough. A pulse below the applicable minimum changes nothing except a sticky error flag. After an accepted pulse ends, memory access stays blocked for a fixed operational delay. The same delay applies to cold and warm resets.

The block also models the internal configuration load. This is a fixed count of cycles with the reset pin low, and it runs only once after the supply becomes steady. The block holds a small flash controller with three modes: Read, Program and Erase. A write strobe starts Program or Erase. A reset pin held low for a bounded number of cycles forces the controller back to Read. While the supply sits below the lockout level, no write starts. The supply-steady flag clears the whole block asynchronously. Its rising edge is synchronised before the block leaves reset.

Top module: `reset_sequencer`

## Requirements
- R1: Once the supply-steady input has been high for the synchroniser depth plus one cycle, with the reset pin high, the outputs are: `ready` 0, `cfg_done` 0, `por_done` 0, `short_err` 0, and `fl_state` 0 (Read).
- R2: Before `por_done` is set, a low pulse of at least COLD_MIN sampled cycles is accepted and sets `por_done`. A shorter pulse leaves `por_done` and `ready` at 0.
- R3: `cfg_done` rises at the clock edge that completes the CFG_CYC-th sampled-low cycle of the reset pin, counted over all pulses since the supply became steady. After that it stays high, including during later warm resets.
- R4: Once `por_done` is set, a pulse of at least WARM_MIN cycles is accepted. A shorter pulse starts no operational delay: `ready` is back high as soon as the pin is high again.
- R5: A rejected pulse sets `short_err` at the edge where the pin is first sampled high. The flag stays set until an accepted pulse clears it at its own release edge.
- R6: After an accepted pulse, `ready` is low until OPR_CYC edges have passed after the release edge, and high from then on. The release edge is the first edge with the pin sampled high.
- R7: `ready` is high only while all of these hold: the pin is high, `por_done` is set, `cfg_done` is set, the delay has expired, and `sup_low` is low.
- R8: A write starts when `wr_n` is sampled low after being sampled high on the previous edge, while at least one `sel` bit is set, `ready` is high and `fl_state` is Read. The new state is Erase (2) if `op_erase` is 1, otherwise Program (1). Read is 0.
- R9: Program occupies PROG_CYC edges including the start edge, and Erase occupies ERASE_CYC edges. Each then returns to Read.
- R10: If the pin is sampled low for ABORT_CYC consecutive edges, `fl_state` is Read after the last of those edges, whatever mode it was in.
- R11: No write starts while `sup_low` is high, or when no `sel` bit is set, or when `wr_n` fell while the reset pin was low and stays low after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sup_ok | input | 1 | Supply steady; low clears the block asynchronously |
| rst_pin_n | input | 1 | Reset pin, active low, synchronous to clk |
| sup_low | input | 1 | Supply below write-lockout level |
| wr_n | input | 1 | Write strobe, active low |
| sel | input | NSEL | Sector select strobes, active high |
| op_erase | input | 1 | 1 = write starts Erase, 0 = Program |
| ready | output | 1 | Memory access allowed |
| cfg_done | output | 1 | Configuration load finished, logic outputs valid |
| por_done | output | 1 | Power-on reset accepted |
| short_err | output | 1 | Sticky flag for a rejected short pulse |
| fl_state | output | 2 | Flash mode: 0 Read, 1 Program, 2 Erase |

## Verification
Pulse lengths are swept on both sides of each threshold. Before power-on, a pulse one cycle short of the cold minimum must fail while the exact minimum passes. After power-on, every length below the warm minimum is tried and must fail, and the exact warm minimum and a longer pulse must pass. This separates the two thresholds and shows which state selects between them. The write path is driven with Program and Erase, with all sectors deselected, under low supply, and with the strobe already low through a reset. Together these separate a true start from each blocking condition. Resets arriving during Program and during Erase show that the abort bound holds whatever the remaining busy time.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
  typedef enum logic [1:0] {
    FL_READ  = 2'd0,
    FL_PROG  = 2'd1,
    FL_ERASE = 2'd2
  } fl_state_e;
endpackage

// File: rtl/rsq_sync.sv
`timescale 1ns/1ps
// Asynchronous clear from supply-steady, synchronous release.
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic sup_ok,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge sup_ok) begin
    if (!sup_ok) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/rsq_pulse.sv
`timescale 1ns/1ps
// Measures reset pin pulses, qualifies them, runs config load and operational delay.
module rsq_pulse #(
  parameter int COLD_MIN  = 40,
  parameter int WARM_MIN  = 8,
  parameter int OPR_CYC   = 12,
  parameter int CFG_CYC   = 20,
  parameter int ABORT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic por_done,
  output logic short_err,
  output logic cfg_done,
  output logic delay_done,
  output logic abort
);
  localparam int CW = $clog2(COLD_MIN + 1);
  localparam int OW = $clog2(OPR_CYC + 1);
  localparam int FW = $clog2(CFG_CYC + 1);
  localparam logic [CW-1:0] COLD_T = CW'(COLD_MIN);
  localparam logic [CW-1:0] WARM_T = CW'(WARM_MIN);
  localparam logic [CW-1:0] ABRT_T = CW'(ABORT_CYC - 1);
  localparam logic [OW-1:0] OPR_T  = OW'(OPR_CYC);
  localparam logic [FW-1:0] CFG_L  = FW'(CFG_CYC - 1);

  logic [CW-1:0] low_q, low_d;
  logic [OW-1:0] op_q, op_d;
  logic [FW-1:0] cfgc_q, cfgc_d;
  logic          por_q, por_d, err_q, err_d, cfgd_q, cfgd_d;
  logic [CW-1:0] thr;
  logic          rel, acc;

  always_comb begin
    thr = por_q ? WARM_T : COLD_T;
    rel = pin_n && (low_q != '0);
    acc = rel && (low_q >= thr);

    low_d = low_q;
    if (pin_n)                low_d = '0;
    else if (low_q != COLD_T) low_d = low_q + 1'b1;

    op_d = op_q;
    if (acc)             op_d = OPR_T;
    else if (op_q != '0) op_d = op_q - 1'b1;

    por_d = por_q | acc;
    err_d = err_q;
    if (rel) err_d = !acc;

    cfgc_d = cfgc_q;
    cfgd_d = cfgd_q;
    if (!cfgd_q && !pin_n) begin
      if (cfgc_q == CFG_L) cfgd_d = 1'b1;
      cfgc_d = cfgc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      op_q   <= '0;
      cfgc_q <= '0;
      por_q  <= 1'b0;
      err_q  <= 1'b0;
      cfgd_q <= 1'b0;
    end else begin
      low_q  <= low_d;
      op_q   <= op_d;
      cfgc_q <= cfgc_d;
      por_q  <= por_d;
      err_q  <= err_d;
      cfgd_q <= cfgd_d;
    end
  end

  assign por_done   = por_q;
  assign short_err  = err_q;
  assign cfg_done   = cfgd_q;
  assign delay_done = (op_q == '0);
  assign abort      = !pin_n && (low_q >= ABRT_T);

  // R5: the error flag only rises one edge after a release edge.
  assert_err_on_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> ($past(pin_n) && !$past(pin_n, 2)));
  // R6: a fresh delay load follows a low-to-high pin transition.
  assert_delay_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OPR_T) |-> ($past(pin_n) && !$past(pin_n, 2)));
  // R3: configuration stays loaded.
  assert_cfg_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfgd_q |=> cfgd_q);
  // R2: power-on acceptance is never withdrawn.
  assert_por_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    por_q |=> por_q);
endmodule

// File: rtl/rsq_flash.sv
`timescale 1ns/1ps
// Flash mode controller: Read / Program / Erase with reset abort and lockout.
module rsq_flash
  import rsq_pkg::*;
#(
  parameter int PROG_CYC  = 30,
  parameter int ERASE_CYC = 60,
  parameter int NSEL      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            abort,
  input  logic            ready,
  input  logic            sup_low,
  input  logic            wr_n,
  input  logic [NSEL-1:0] sel,
  input  logic            op_erase,
  output fl_state_e       state
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] PROG_T  = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] ERASE_T = TW'(ERASE_CYC - 1);
  localparam logic [TW-1:0] MAX_T   = TW'(MAXC);

  fl_state_e     st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          wr_q, fall, accept;

  always_comb begin
    fall   = wr_q && !wr_n;
    accept = fall && (|sel) && ready && !sup_low && (st_q == FL_READ);
    st_d   = st_q;
    tmr_d  = tmr_q;
    if (abort) begin
      st_d  = FL_READ;
      tmr_d = '0;
    end else if (st_q == FL_READ) begin
      if (accept) begin
        st_d  = op_erase ? FL_ERASE : FL_PROG;
        tmr_d = op_erase ? ERASE_T : PROG_T;
      end
    end else if (tmr_q == '0) begin
      st_d = FL_READ;
    end else begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FL_READ;
      tmr_q <= '0;
      wr_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      wr_q  <= wr_n;
    end
  end

  assign state = st_q;

  assert_abort_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (st_q == FL_READ));
  assert_lockout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FL_READ && sup_low) |=> (st_q == FL_READ));
  assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != FL_READ) |-> (tmr_q < MAX_T));
endmodule

// File: rtl/reset_sequencer.sv
`timescale 1ns/1ps
module reset_sequencer
  import rsq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int COLD_MIN    = 40,
  parameter int WARM_MIN    = 8,
  parameter int OPR_CYC     = 12,
  parameter int CFG_CYC     = 20,
  parameter int ABORT_CYC   = 3,
  parameter int PROG_CYC    = 30,
  parameter int ERASE_CYC   = 60,
  parameter int NSEL        = 4
) (
  input  logic            clk,
  input  logic            sup_ok,
  input  logic            rst_pin_n,
  input  logic            sup_low,
  input  logic            wr_n,
  input  logic [NSEL-1:0] sel,
  input  logic            op_erase,
  output logic            ready,
  output logic            cfg_done,
  output logic            por_done,
  output logic            short_err,
  output logic [1:0]      fl_state
);
  logic      rst_n, delay_done, abort;
  fl_state_e st;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .sup_ok(sup_ok), .rst_n(rst_n)
  );

  rsq_pulse #(
    .COLD_MIN(COLD_MIN), .WARM_MIN(WARM_MIN), .OPR_CYC(OPR_CYC),
    .CFG_CYC(CFG_CYC), .ABORT_CYC(ABORT_CYC)
  ) u_pulse (
    .clk(clk), .rst_n(rst_n), .pin_n(rst_pin_n),
    .por_done(por_done), .short_err(short_err), .cfg_done(cfg_done),
    .delay_done(delay_done), .abort(abort)
  );

  assign ready = rst_pin_n && por_done && cfg_done && delay_done && !sup_low;

  rsq_flash #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .NSEL(NSEL)) u_flash (
    .clk(clk), .rst_n(rst_n), .abort(abort), .ready(ready), .sup_low(sup_low),
    .wr_n(wr_n), .sel(sel), .op_erase(op_erase), .state(st)
  );

  assign fl_state = st;

  // R8: no write can start before the power-on reset has been accepted.
  assert_no_early_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |=> (fl_state == FL_READ));
endmodule

// File: tb/sim_reset_sequencer.sv
`timescale 1ns/1ps
module sim_reset_sequencer;
  localparam int COLD = 40, WARM = 8, OPR = 12, CFG = 20, ABRT = 3;
  localparam int PROG = 30, ERAS = 60, NS = 4;

  logic clk = 1'b0;
  logic sup_ok, rst_pin_n, sup_low, wr_n, op_erase;
  logic [NS-1:0] sel;
  logic ready, cfg_done, por_done, short_err;
  logic [1:0] fl_state;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reset_sequencer #(
    .SYNC_STAGES(2), .COLD_MIN(COLD), .WARM_MIN(WARM), .OPR_CYC(OPR),
    .CFG_CYC(CFG), .ABORT_CYC(ABRT), .PROG_CYC(PROG), .ERASE_CYC(ERAS), .NSEL(NS)
  ) u0 (
    .clk(clk), .sup_ok(sup_ok), .rst_pin_n(rst_pin_n), .sup_low(sup_low),
    .wr_n(wr_n), .sel(sel), .op_erase(op_erase), .ready(ready),
    .cfg_done(cfg_done), .por_done(por_done), .short_err(short_err),
    .fl_state(fl_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Pin low for exactly k sampled edges, returns at the negedge where it goes high.
  task automatic pulse(input int k);
    rst_pin_n = 1'b0;
    nc(k);
    rst_pin_n = 1'b1;
  endtask

  task automatic ready_timing(input string req);
    nc(OPR);
    chk(req, ready, 0);
    nc(1);
    chk(req, ready, 1);
  endtask

  task automatic write_op(input bit er, input logic [NS-1:0] s, input bit expect_go,
                          input string req);
    int dur;
    dur = er ? ERAS : PROG;
    sel = s; op_erase = er; wr_n = 1'b0;
    nc(1);
    chk(req, fl_state, expect_go ? (er ? 2 : 1) : 0);
    if (expect_go) begin
      nc(dur - 1);
      chk("R9", fl_state, er ? 2 : 1);
      nc(1);
      chk("R9", fl_state, 0);
    end
    wr_n = 1'b1; sel = '0;
    nc(2);
  endtask

  task automatic abort_op(input bit er);
    sel = 4'b0010; op_erase = er; wr_n = 1'b0;
    nc(1);
    chk("R8", fl_state, er ? 2 : 1);
    wr_n = 1'b1; sel = '0;
    nc(5);
    rst_pin_n = 1'b0;
    nc(ABRT - 1);
    chk("R10", fl_state, er ? 2 : 1);
    chk("R7", ready, 0);
    nc(1);
    chk("R10", fl_state, 0);
    nc(WARM - ABRT);
    rst_pin_n = 1'b1;
    ready_timing("R6");
  endtask

  initial begin
    sup_ok = 1'b1; rst_pin_n = 1'b1; sup_low = 1'b0; wr_n = 1'b1;
    sel = '0; op_erase = 1'b0;
    #3 sup_ok = 1'b0;
    nc(3);
    sup_ok = 1'b1;
    nc(3);
    // R1: state just after supply becomes steady
    chk("R1", ready, 0); chk("R1", cfg_done, 0); chk("R1", por_done, 0);
    chk("R1", short_err, 0); chk("R1", fl_state, 0);

    // R2/R5: short cold pulse below CFG length
    pulse(5); nc(1);
    chk("R2", por_done, 0); chk("R5", short_err, 1); chk("R3", cfg_done, 0);
    chk("R2", ready, 0);
    // R3: config load completes after CFG cumulative low edges
    rst_pin_n = 1'b0;
    nc(CFG - 5 - 1);
    chk("R3", cfg_done, 0);
    nc(1);
    chk("R3", cfg_done, 1);
    nc(COLD - 1 - (CFG - 5));
    rst_pin_n = 1'b1; nc(1);
    chk("R2", por_done, 0); chk("R5", short_err, 1); chk("R2", ready, 0);

    // R2: exact cold minimum accepted
    pulse(COLD);
    ready_timing("R6");
    chk("R2", por_done, 1); chk("R5", short_err, 0);

    // R4: sweep of every warm length below the minimum
    for (int k = 1; k < WARM; k++) begin
      pulse(k);
      nc(1);
      chk("R4", ready, 1);
      chk("R5", short_err, 1);
    end
    // R4: warm minimum and a longer warm pulse both accepted
    rst_pin_n = 1'b0;
    nc(2);
    chk("R3", cfg_done, 1);
    chk("R7", ready, 0);
    nc(WARM - 2);
    rst_pin_n = 1'b1;
    ready_timing("R6");
    chk("R5", short_err, 0);
    pulse(WARM + 5);
    ready_timing("R4");

    // R8/R9: program and erase
    write_op(1'b0, 4'b0001, 1'b1, "R8");
    write_op(1'b1, 4'b1000, 1'b1, "R8");
    // R11: no sector selected
    write_op(1'b0, 4'b0000, 1'b0, "R11");
    // R7/R11: supply below lockout
    sup_low = 1'b1; nc(1);
    chk("R7", ready, 0);
    write_op(1'b1, 4'b0100, 1'b0, "R11");
    sup_low = 1'b0; nc(1);
    chk("R7", ready, 1);

    // R10: abort during program and during erase
    abort_op(1'b0);
    abort_op(1'b1);

    // R11: strobe falls during reset and is held low after release
    sel = 4'b0001; op_erase = 1'b0;
    rst_pin_n = 1'b0; wr_n = 1'b0;
    nc(WARM);
    rst_pin_n = 1'b1;
    ready_timing("R6");
    nc(3);
    chk("R11", fl_state, 0);
    wr_n = 1'b1; sel = '0;
    nc(2);
    write_op(1'b0, 4'b0001, 1'b1, "R8");

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule